// File: doc/BRIEF.md
# Randomized Pulse Performance Throttler

This block slows a multi-threaded processor by withholding issue slots in a pseudo-random pattern. Each cycle it draws the low byte of a maximal-length 16-bit LFSR and grants the slot when that byte does not exceed the applied throttle level. Level 255 never withholds a slot and level 0 grants about one slot in 256, so throughput can be set in steps of 1/256. The random draw keeps the gating pattern from having a fixed period, so it does not inject a tone into the supply current.

The applied level is held in three registers. The limit is loaded by the upstream limiting controller. The ceiling is trimmed by a slow thermal loop on a prescaled tick. The working level is cut sharply by a fast current-violation input and then climbs back to the ceiling one step at a time. Granted slots are handed to hardware threads in round-robin order, with the pointer moving only on a grant, so the withheld slots are spread evenly across the threads.

Top module: `rpm_throttle`

## Requirements
- R1: While reset is held and right after it, `level_o` is 255, `slot_en` is 0 and `thread_en` is all zeros.
- R2: A cycle with `ctrl_load` high sets the limit, the ceiling and the working level to `ctrl_level`, and the new value is visible on `level_o` after that clock edge.
- R3: `slot_en` is registered. It is high in the cycle after an edge at which the LFSR low byte was less than or equal to the level shown on `level_o` before that edge. A level of 255 grants every cycle.
- R4: Over any 65535 consecutive cycles at a fixed level L, `slot_en` is high in exactly 256·(L+1)−1 cycles.
- R5: A rising edge of `cur_viol` lowers the working level by `cur_step`, saturating at 0, at the same clock edge. The lowered level governs `slot_en` from the next edge on. A level held high cuts the level only once.
- R6: While `cur_viol` is high the level never rises. Once it is low, the level rises by one every `rec_period` cycles (0 is treated as 1) until it reaches the ceiling, and never goes past it.
- R7: With `tick_div` nonzero, a thermal tick occurs every `tick_div` cycles. On a tick, a high `therm_viol` lowers the ceiling by one (floor 0); otherwise the ceiling rises by one, up to the loaded limit. The working level never exceeds the ceiling. `tick_div` = 0 stops all ticks.
- R8: `thread_en` is one-hot or zero, and it is nonzero exactly when `slot_en` is high. Successive grants go to threads 0, 1, …, THREADS−1 and then wrap. The pointer moves only on a grant, and the first grant after reset goes to thread 0.
- R9: Over any run of grants, the grant counts of any two threads differ by at most one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_load | input | 1 | Load strobe for the throttle limit |
| ctrl_level | input | LVL_W | Throttle limit from the controller |
| cur_viol | input | 1 | Fast peak-current violation flag |
| cur_step | input | LVL_W | Level cut applied per current violation |
| rec_period | input | REC_W | Cycles per one-step recovery |
| therm_viol | input | 1 | Slow thermal violation flag |
| tick_div | input | PRE_W | Thermal tick prescaler, 0 disables |
| slot_en | output | 1 | Per-cycle issue enable |
| thread_en | output | THREADS | One-hot per-thread issue enable |
| level_o | output | LVL_W | Level currently applied |

## Verification
The assertions assume that `cur_viol` and `ctrl_load` are low throughout reset. Without that, the first `$rose` after reset would have no real edge behind it. The cut and no-recovery properties also assume that a load never coincides with a violation edge they are checking, so the antecedents exclude load cycles. The bench drives every input at the falling edge and keeps the control values (`cur_step`, `rec_period`, `tick_div`) stable while a scenario runs. It raises violations only after a load has settled, so each stimulus has a single, known effect on the level.

// File: rtl/rpm_pkg.sv
package rpm_pkg;
  // Kind of update applied to the working level in a cycle, in priority order.
  typedef enum logic [1:0] {
    LV_HOLD = 2'd0,
    LV_CUT  = 2'd1,
    LV_RISE = 2'd2,
    LV_LOAD = 2'd3
  } lvl_act_e;
endpackage

// File: rtl/rpm_level_ctrl.sv
module rpm_level_ctrl #(
  parameter int LVL_W = 8,
  parameter int REC_W = 16,
  parameter int PRE_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [LVL_W-1:0] ld_val,
  input  logic             cur_viol,
  input  logic [LVL_W-1:0] cur_step,
  input  logic [REC_W-1:0] rec_period,
  input  logic             therm_viol,
  input  logic [PRE_W-1:0] tick_div,
  output logic [LVL_W-1:0] lvl_o,
  output logic [LVL_W-1:0] ceil_o
);
  import rpm_pkg::*;

  localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};
  localparam logic [LVL_W-1:0] LVL_ONE = {{(LVL_W-1){1'b0}}, 1'b1};

  logic [LVL_W-1:0] lim_q, ceil_q, lvl_q, ceil_d, lvl_pre, lvl_d;
  logic             cur_prev_q, cur_rise, tick, rec_due;
  logic [REC_W-1:0] rec_cnt_q, rec_cnt_d;
  logic [PRE_W-1:0] pre_cnt_q, pre_cnt_d;
  logic [REC_W:0]   rec_inc;
  logic [PRE_W:0]   pre_inc;
  lvl_act_e         act;

  assign cur_rise = cur_viol & ~cur_prev_q;

  // Thermal tick prescaler
  assign pre_inc = {1'b0, pre_cnt_q} + {{PRE_W{1'b0}}, 1'b1};
  assign tick    = (tick_div != '0) && (pre_inc >= {1'b0, tick_div});
  assign pre_cnt_d = (tick_div == '0 || tick) ? '0 : pre_inc[PRE_W-1:0];

  // Slow loop acts on the ceiling
  always_comb begin
    ceil_d = ceil_q;
    if (ld)                                   ceil_d = ld_val;
    else if (tick && therm_viol && ceil_q != '0) ceil_d = ceil_q - LVL_ONE;
    else if (tick && !therm_viol && ceil_q < lim_q) ceil_d = ceil_q + LVL_ONE;
  end

  // Recovery pacing
  assign rec_inc = {1'b0, rec_cnt_q} + {{REC_W{1'b0}}, 1'b1};
  assign rec_due = !cur_viol && (lvl_q < ceil_q) && (rec_inc >= {1'b0, rec_period});
  assign rec_cnt_d = (ld || cur_viol || lvl_q >= ceil_q || rec_due) ? '0 : rec_inc[REC_W-1:0];

  // Fast loop acts on the working level
  always_comb begin
    if (ld)            act = LV_LOAD;
    else if (cur_rise) act = LV_CUT;
    else if (rec_due)  act = LV_RISE;
    else               act = LV_HOLD;
  end

  always_comb begin
    case (act)
      LV_LOAD: lvl_pre = ld_val;
      LV_CUT:  lvl_pre = (lvl_q > cur_step) ? lvl_q - cur_step : '0;
      LV_RISE: lvl_pre = lvl_q + LVL_ONE;
      default: lvl_pre = lvl_q;
    endcase
    lvl_d = (lvl_pre > ceil_d) ? ceil_d : lvl_pre;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim_q      <= LVL_MAX;
      ceil_q     <= LVL_MAX;
      lvl_q      <= LVL_MAX;
      cur_prev_q <= 1'b0;
      rec_cnt_q  <= '0;
      pre_cnt_q  <= '0;
    end else begin
      if (ld) lim_q <= ld_val;
      ceil_q     <= ceil_d;
      lvl_q      <= lvl_d;
      cur_prev_q <= cur_viol;
      rec_cnt_q  <= rec_cnt_d;
      pre_cnt_q  <= pre_cnt_d;
    end
  end

  assign lvl_o  = lvl_q;
  assign ceil_o = ceil_q;
endmodule

// File: rtl/rpm_pulse_gen.sv
module rpm_pulse_gen #(
  parameter int                LVL_W  = 8,
  parameter int                LFSR_W = 16,
  parameter logic [LFSR_W-1:0] TAPS   = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED   = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] lvl,
  output logic             slot_go
);
  logic [LFSR_W-1:0] lfsr_q, lfsr_d;

  // Galois form, right shift
  assign lfsr_d  = lfsr_q[0] ? ((lfsr_q >> 1) ^ TAPS) : (lfsr_q >> 1);
  assign slot_go = (lfsr_q[LVL_W-1:0] <= lvl);

  always_ff @(posedge clk) begin
    if (!rst_n) lfsr_q <= SEED;
    else        lfsr_q <= lfsr_d;
  end
endmodule

// File: rtl/rpm_thread_rr.sv
module rpm_thread_rr #(
  parameter int THREADS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  output logic               en_o,
  output logic [THREADS-1:0] thr_o
);
  localparam int PTR_W = (THREADS > 1) ? $clog2(THREADS) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(THREADS - 1);

  logic [PTR_W-1:0]   ptr_q;
  logic [THREADS-1:0] thr_d;
  logic               en_q;
  logic [THREADS-1:0] thr_q;

  for (genvar i = 0; i < THREADS; i++) begin : g_sel
    assign thr_d[i] = go && (ptr_q == PTR_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      en_q  <= 1'b0;
      thr_q <= '0;
    end else begin
      en_q  <= go;
      thr_q <= thr_d;
      if (go) ptr_q <= (ptr_q == PTR_LAST) ? '0 : ptr_q + PTR_W'(1);
    end
  end

  assign en_o  = en_q;
  assign thr_o = thr_q;
endmodule

// File: rtl/rpm_throttle.sv
module rpm_throttle #(
  parameter int LVL_W   = 8,
  parameter int LFSR_W  = 16,
  parameter int THREADS = 4,
  parameter int REC_W   = 16,
  parameter int PRE_W   = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_load,
  input  logic [LVL_W-1:0]   ctrl_level,
  input  logic               cur_viol,
  input  logic [LVL_W-1:0]   cur_step,
  input  logic [REC_W-1:0]   rec_period,
  input  logic               therm_viol,
  input  logic [PRE_W-1:0]   tick_div,
  output logic               slot_en,
  output logic [THREADS-1:0] thread_en,
  output logic [LVL_W-1:0]   level_o
);
  logic [LVL_W-1:0] lvl_w, ceil_w;
  logic             go_w;

  rpm_level_ctrl #(.LVL_W(LVL_W), .REC_W(REC_W), .PRE_W(PRE_W)) u_level (
    .clk(clk), .rst_n(rst_n), .ld(ctrl_load), .ld_val(ctrl_level),
    .cur_viol(cur_viol), .cur_step(cur_step), .rec_period(rec_period),
    .therm_viol(therm_viol), .tick_div(tick_div),
    .lvl_o(lvl_w), .ceil_o(ceil_w)
  );

  rpm_pulse_gen #(.LVL_W(LVL_W), .LFSR_W(LFSR_W)) u_pulse (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_w), .slot_go(go_w)
  );

  rpm_thread_rr #(.THREADS(THREADS)) u_rr (
    .clk(clk), .rst_n(rst_n), .go(go_w), .en_o(slot_en), .thr_o(thread_en)
  );

  assign level_o = lvl_w;
endmodule

// File: rtl/rpm_throttle_chk.sv
module rpm_throttle_chk #(
  parameter int LVL_W   = 8,
  parameter int THREADS = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ctrl_load,
  input logic               cur_viol,
  input logic [LVL_W-1:0]   cur_step,
  input logic               slot_en,
  input logic [THREADS-1:0] thread_en,
  input logic [LVL_W-1:0]   level_o,
  input logic [LVL_W-1:0]   ceil_q
);
  AST_THREAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(thread_en)); // R8
  AST_THREAD_WITH_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    slot_en == (thread_en != '0)); // R8
  AST_FULL_LEVEL_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o == {LVL_W{1'b1}}) |=> slot_en); // R3
  AST_CUT_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cur_viol) && !ctrl_load && level_o != '0 && cur_step != '0) |=> (level_o < $past(level_o))); // R5
  AST_NO_RISE_IN_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_viol && !ctrl_load) |=> (level_o <= $past(level_o))); // R6
  AST_LEVEL_UNDER_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    level_o <= ceil_q); // R7
endmodule

bind rpm_throttle rpm_throttle_chk #(.LVL_W(LVL_W), .THREADS(THREADS)) chk_i (
  .clk(clk), .rst_n(rst_n), .ctrl_load(ctrl_load), .cur_viol(cur_viol),
  .cur_step(cur_step), .slot_en(slot_en), .thread_en(thread_en),
  .level_o(level_o), .ceil_q(ceil_w)
);

// File: tb/rpm_throttle_tb_top.sv
module rpm_throttle_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int THREADS    = 4;
  localparam int PERIOD     = 65535;
  localparam int WDOG       = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_load = 1'b0;
  logic [7:0]  ctrl_level = 8'd0;
  logic        cur_viol = 1'b0;
  logic [7:0]  cur_step = 8'd0;
  logic [15:0] rec_period = 16'd1;
  logic        therm_viol = 1'b0;
  logic [19:0] tick_div = 20'd0;
  logic        slot_en;
  logic [THREADS-1:0] thread_en;
  logic [7:0]  level_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rpm_throttle dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_load(ctrl_load), .ctrl_level(ctrl_level),
    .cur_viol(cur_viol), .cur_step(cur_step), .rec_period(rec_period),
    .therm_viol(therm_viol), .tick_div(tick_div),
    .slot_en(slot_en), .thread_en(thread_en), .level_o(level_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_level(input logic [7:0] v);
    ctrl_load = 1'b1; ctrl_level = v;
    step(1);
    ctrl_load = 1'b0;
    check(level_o == v, "R2 level after load", level_o, v);
  endtask

  task automatic t_reset;
    step(2);
    check(level_o == 8'hFF, "R1 reset level", level_o, 255);
    check(slot_en == 1'b0, "R1 reset slot_en", slot_en, 0);
    check(thread_en == '0, "R1 reset thread_en", thread_en, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_full_level;
    int bad_en = 0, bad_thr = 0;
    for (int k = 0; k < 300; k++) begin
      step(1);
      if (!slot_en) bad_en++;
      if (thread_en != (4'b1 << (k % THREADS))) bad_thr++;
    end
    check(bad_en == 0, "R3 level 255 grants every cycle", bad_en, 0);
    check(bad_thr == 0, "R8 round-robin grant order from thread 0", bad_thr, 0);
  endtask

  task automatic t_period_63;
    int cnt = 0, bad = 0, mx = 0, mn = PERIOD;
    int per[THREADS];
    for (int i = 0; i < THREADS; i++) per[i] = 0;
    load_level(8'd63);
    step(1);
    for (int k = 0; k < PERIOD; k++) begin
      step(1);
      if (slot_en) cnt++;
      if (slot_en != (thread_en != '0)) bad++;
      for (int i = 0; i < THREADS; i++) if (thread_en[i]) per[i]++;
    end
    for (int i = 0; i < THREADS; i++) begin
      if (per[i] > mx) mx = per[i];
      if (per[i] < mn) mn = per[i];
    end
    check(cnt == 256*64-1, "R4 grants per period at level 63", cnt, 256*64-1);
    check(bad == 0, "R8 thread_en tracks slot_en", bad, 0);
    check(mx - mn <= 1, "R9 thread grant spread", mx - mn, 1);
  endtask

  task automatic t_cut_and_recover;
    load_level(8'd200);
    cur_step = 8'd30; rec_period = 16'd5;
    cur_viol = 1'b1;
    step(1);
    check(level_o == 8'd170, "R5 cut by step on violation edge", level_o, 170);
    step(3);
    check(level_o == 8'd170, "R5 held violation cuts once", level_o, 170);
    cur_viol = 1'b0;
    step(4);
    check(level_o == 8'd170, "R6 no rise before period", level_o, 170);
    step(1);
    check(level_o == 8'd171, "R6 rise after rec_period cycles", level_o, 171);
    step(300);
    check(level_o == 8'd200, "R6 recovery stops at ceiling", level_o, 200);
  endtask

  task automatic t_saturate;
    load_level(8'd10);
    cur_step = 8'd40;
    cur_viol = 1'b1;
    step(1);
    check(level_o == 8'd0, "R5 cut saturates at zero", level_o, 0);
    cur_viol = 1'b0;
    rec_period = 16'd1;
    step(20);
    check(level_o == 8'd10, "R6 recovers to loaded level", level_o, 10);
  endtask

  task automatic t_thermal;
    load_level(8'd100);
    rec_period = 16'd1;
    therm_viol = 1'b1;
    tick_div = 20'd10;
    step(9);
    check(level_o == 8'd100, "R7 no tick before prescale", level_o, 100);
    step(1);
    check(level_o == 8'd99, "R7 hot tick lowers level", level_o, 99);
    step(40);
    check(level_o == 8'd95, "R7 five hot ticks", level_o, 95);
    therm_viol = 1'b0;
    step(200);
    check(level_o == 8'd100, "R7 cool ticks stop at limit", level_o, 100);
    tick_div = 20'd0;
    therm_viol = 1'b1;
    step(100);
    check(level_o == 8'd100, "R7 zero prescale disables ticks", level_o, 100);
    therm_viol = 1'b0;
  endtask

  task automatic t_fast_cut_period;
    int cnt = 0;
    load_level(8'd255);
    step(2);
    cur_step = 8'd255;
    cur_viol = 1'b1;
    step(1);
    check(level_o == 8'd0, "R5 full cut in one edge", level_o, 0);
    check(slot_en == 1'b1, "R3 slot from level before cut", slot_en, 1);
    for (int k = 0; k < PERIOD; k++) begin
      step(1);
      if (slot_en) cnt++;
    end
    check(cnt == 255, "R4 R5 grants per period at level 0", cnt, 255);
    cur_viol = 1'b0;
  endtask

  initial begin
    step(WDOG);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_full_level();
    t_period_63();
    t_cut_and_recover();
    t_saturate();
    t_thermal();
    t_fast_cut_period();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule